// File: doc/BRIEF.md
# Key-Unlocked Configuration Register Bank

This block holds a 64-entry bank of 16-bit registers behind a single-cycle synchronous request port. Every request carries an index, a write flag and write data, and gets an answer in the next cycle. A write gets an acknowledge pulse. A read gets a read-valid pulse together with the data. An index past the end of the bank gets an error pulse.

Most of the bank is fixed status words. Index 31 is a key register. Indices 32 to 47 form a user configuration band that software can change only after the key has been given. Writing the key value opens the band. Writing any other value to the key register closes the band again.

A write into the band while it is closed is still acknowledged, but the write has no effect. Software therefore cannot tell a dropped write from an accepted one by looking at the handshake. It has to read the register back. The key register reads back only the lock state, so the key value itself is never visible on the read port.

Top module: `keyed_cfg_bank`

## Requirements
- R1: After reset the band is closed, all band registers read 0x0000, the key register reads 0x0000, and wr_ack, rd_valid and req_err are low.
- R2: A write of 0x1235 to index 31 opens the band. From then on, a read of index 31 returns 0x0001.
- R3: A write of any value other than 0x1235 to index 31 closes the band. From then on, a read of index 31 returns 0x0000.
- R4: While the band is closed, a write to an index in 32..47 is acknowledged, and the register keeps its previous value.
- R5: While the band is open, a write to an index in 32..47 stores the write data. A later read of that index returns it.
- R6: Indices 0..30 and 48..63 are read-only status words. Each one reads as 0xC000 OR its index. Writes to them are acknowledged and change nothing.
- R7: A read of an index below 64 produces rd_valid for exactly one cycle, in the cycle after the request, with rd_data holding the addressed contents.
- R8: A write to an index below 64 produces wr_ack for exactly one cycle, in the cycle after the request, whatever the lock state.
- R9: A request to an index of 64 or above produces req_err for exactly one cycle, in the cycle after the request. It produces no wr_ack and no rd_valid, and it changes no register and not the lock state.
- R10: A read of the key register returns only 0x0000 or 0x0001, and never the key value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Register index, 0..127 |
| req_wdata | input | 16 | Write data |
| wr_ack | output | 1 | Write acknowledge, one-cycle pulse |
| rd_valid | output | 1 | Read data valid, one-cycle pulse |
| rd_data | output | 16 | Read data, meaningful while rd_valid is high |
| req_err | output | 1 | Index out of range, one-cycle pulse |

## Verification
All 128 indices are read back after each phase: after reset, after a write to every index with the band closed, after a pattern is written with the band open, and after a wave of out-of-range writes. Each sweep separates the status words, the key register, the band and the invalid range in one pass.

Near-miss key values (0x1234, 0x1236, 0x3512, 0x0000 and 0xFFFF) are checked to keep or restore the lock. This catches a compare that looks at too few bits. The key value written to index 95 catches an index decoder that drops the top address bit. Each band pattern is derived from its index, so a write that lands on the wrong entry shows up as a mismatch.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  // Classification of a request index
  typedef enum logic [1:0] {
    REG_STATUS  = 2'd0,
    REG_KEY     = 2'd1,
    REG_BAND    = 2'd2,
    REG_INVALID = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/cfgbank_decode.sv
module cfgbank_decode
  import cfgbank_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int NUM_REGS = 64,
  parameter int KEY_IDX  = 31,
  parameter int BAND_LO  = 32,
  parameter int BAND_HI  = 47,
  parameter int IDX_W    = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [IDX_W-1:0]  band_idx
);
  always_comb begin
    if (int'(addr) >= NUM_REGS)
      kind = REG_INVALID;
    else if (int'(addr) == KEY_IDX)
      kind = REG_KEY;
    else if (int'(addr) >= BAND_LO && int'(addr) <= BAND_HI)
      kind = REG_BAND;
    else
      kind = REG_STATUS;
  end

  assign band_idx = IDX_W'(addr - ADDR_W'(BAND_LO));
endmodule

// File: rtl/cfgbank_lock.sv
module cfgbank_lock #(
  parameter int                DATA_W    = 16,
  parameter logic [DATA_W-1:0] KEY_VALUE = 16'h1235
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked
);
  logic unlocked_q;

  always_ff @(posedge clk) begin
    if (rst)
      unlocked_q <= 1'b0;
    else if (key_we)
      unlocked_q <= (wdata == KEY_VALUE);
  end

  assign unlocked = unlocked_q;

  // R2
  key_open_chk: assert property (@(posedge clk) disable iff (rst)
    (key_we && wdata == KEY_VALUE) |=> unlocked_q);

  // R3
  key_close_chk: assert property (@(posedge clk) disable iff (rst)
    (key_we && wdata != KEY_VALUE) |=> !unlocked_q);

  // R3
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !key_we |=> $stable(unlocked_q));
endmodule

// File: rtl/cfgbank_store.sv
module cfgbank_store #(
  parameter int DATA_W = 16,
  parameter int BAND_N = 16,
  parameter int IDX_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic                          unlocked,
  input  logic [IDX_W-1:0]              idx,
  input  logic [DATA_W-1:0]             wdata,
  output logic [BAND_N-1:0][DATA_W-1:0] band_q
);
  for (genvar i = 0; i < BAND_N; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)
        band_q[i] <= '0;
      else if (we && unlocked && idx == IDX_W'(i))
        band_q[i] <= wdata;
    end
  end

  // R4
  locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> $stable(band_q));

  // R5
  open_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we && unlocked) |=> (band_q[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/keyed_cfg_bank.sv
module keyed_cfg_bank
  import cfgbank_pkg::*;
#(
  parameter int                DATA_W     = 16,
  parameter int                ADDR_W     = 7,
  parameter int                NUM_REGS   = 64,
  parameter int                KEY_IDX    = 31,
  parameter int                BAND_LO    = 32,
  parameter int                BAND_HI    = 47,
  parameter logic [DATA_W-1:0] KEY_VALUE  = 16'h1235,
  parameter logic [7:0]        STATUS_TAG = 8'hC0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              wr_ack,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              req_err
);
  localparam int BAND_N = BAND_HI - BAND_LO + 1;
  localparam int IDX_W  = (BAND_N > 1) ? $clog2(BAND_N) : 1;

  reg_kind_e                    kind;
  logic [IDX_W-1:0]             band_idx;
  logic                         unlocked;
  logic [BAND_N-1:0][DATA_W-1:0] band_q;
  logic [DATA_W-1:0]            rd_mux;
  logic [DATA_W-1:0]            status_val;
  logic                         key_we, band_we, in_range;

  logic              wr_ack_q, rd_valid_q, err_q;
  logic [DATA_W-1:0] rd_data_q;

  cfgbank_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .KEY_IDX(KEY_IDX),
    .BAND_LO(BAND_LO), .BAND_HI(BAND_HI), .IDX_W(IDX_W)
  ) u_decode (
    .addr(req_addr), .kind(kind), .band_idx(band_idx)
  );

  assign in_range = (kind != REG_INVALID);
  assign key_we   = req_valid && req_write && (kind == REG_KEY);
  assign band_we  = req_valid && req_write && (kind == REG_BAND);

  cfgbank_lock #(.DATA_W(DATA_W), .KEY_VALUE(KEY_VALUE)) u_lock (
    .clk(clk), .rst(rst), .key_we(key_we), .wdata(req_wdata),
    .unlocked(unlocked)
  );

  cfgbank_store #(.DATA_W(DATA_W), .BAND_N(BAND_N), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .we(band_we), .unlocked(unlocked),
    .idx(band_idx), .wdata(req_wdata), .band_q(band_q)
  );

  // Status word: tag in the upper byte, index in the low bits
  assign status_val = (DATA_W'(STATUS_TAG) << 8) | DATA_W'(req_addr);

  always_comb begin
    case (kind)
      REG_KEY:  rd_mux = DATA_W'(unlocked);
      REG_BAND: rd_mux = band_q[band_idx];
      default:  rd_mux = status_val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ack_q   <= 1'b0;
      rd_valid_q <= 1'b0;
      err_q      <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      wr_ack_q   <= req_valid && req_write && in_range;
      rd_valid_q <= req_valid && !req_write && in_range;
      err_q      <= req_valid && !in_range;
      if (req_valid && !req_write && in_range)
        rd_data_q <= rd_mux;
    end
  end

  assign wr_ack   = wr_ack_q;
  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
  assign req_err  = err_q;

  // R8
  ack_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && int'(req_addr) < NUM_REGS) |=> wr_ack);

  // R7
  rdv_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && int'(req_addr) < NUM_REGS) |=> rd_valid);

  // R9
  err_after_bad_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && int'(req_addr) >= NUM_REGS) |=> (req_err && !wr_ack && !rd_valid));

  // R9
  ack_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({wr_ack, rd_valid, req_err}) <= 1);

  // R10
  key_hidden_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && kind == REG_KEY) |=> (rd_data <= DATA_W'(1)));
endmodule

// File: tb/tb_keyed_cfg_bank.sv
`timescale 1ns/1ps
module tb_keyed_cfg_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [6:0]  req_addr  = '0;
  logic [15:0] req_wdata = '0;
  logic        wr_ack, rd_valid, req_err;
  logic [15:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;

  // Reference state kept by the bench
  logic [15:0] m_band [16];
  bit          m_unl;

  always #2.5 clk = ~clk;

  keyed_cfg_bank dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .wr_ack(wr_ack),
    .rd_valid(rd_valid), .rd_data(rd_data), .req_err(req_err)
  );

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(int a);
    if (a == 31) return {15'd0, m_unl};
    if (a >= 32 && a <= 47) return m_band[a-32];
    return 16'hC000 | 16'(a);
  endfunction

  task automatic req(bit w, int a, logic [15:0] d, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = 7'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (a >= 64) begin
      check("R9 err", {15'd0, req_err}, 16'd1);
      check("R9 no ack/rdv", {14'd0, wr_ack, rd_valid}, 16'd0);
    end else if (w) begin
      check("R8 ack", {15'd0, wr_ack}, 16'd1);
      check("R8 no rdv/err", {14'd0, rd_valid, req_err}, 16'd0);
      if (a == 31) m_unl = (d == 16'h1235);
      else if (a >= 32 && a <= 47 && m_unl) m_band[a-32] = d;
    end else begin
      check("R7 rdv", {15'd0, rd_valid}, 16'd1);
      check("R7 no ack/err", {14'd0, wr_ack, req_err}, 16'd0);
      check(tag, rd_data, exp_read(a));
      if (a == 31) check("R10 key hidden", {15'd0, rd_data > 16'd1}, 16'd0);
    end
    @(negedge clk);
    check("R7 R8 R9 single pulse", {13'd0, wr_ack, rd_valid, req_err}, 16'd0);
  endtask

  task automatic sweep(string tag);
    for (int a = 0; a < 128; a++) begin
      if (a < 31 || (a > 47 && a < 64)) req(1'b0, a, 16'h0, "R6 status");
      else req(1'b0, a, 16'h0, tag);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_band[i] = 16'h0;
    m_unl = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: outputs quiet after reset
    check("R1 outputs", {13'd0, wr_ack, rd_valid, req_err}, 16'd0);
    sweep("R1 reset contents");

    // R4, R6: write every index while the band is closed
    for (int a = 0; a < 128; a++) req(1'b1, a, 16'hA000 ^ 16'(a), "");
    sweep("R4 locked write");

    // R3: near-miss keys keep the band closed
    req(1'b1, 31, 16'h1234, ""); req(1'b0, 31, 0, "R3 key 1234");
    req(1'b1, 31, 16'h1236, ""); req(1'b0, 31, 0, "R3 key 1236");
    req(1'b1, 31, 16'h3512, ""); req(1'b0, 31, 0, "R3 key 3512");
    // R9: key value to an aliased out-of-range index must not unlock
    req(1'b1, 95, 16'h1235, ""); req(1'b0, 31, 0, "R9 alias no unlock");

    // R2, R5: open and fill the band
    req(1'b1, 31, 16'h1235, ""); req(1'b0, 31, 0, "R2 unlock");
    for (int a = 32; a <= 47; a++) req(1'b1, a, 16'(a) * 16'h0101 + 16'd7, "");
    sweep("R5 open write");

    // R3: any other key closes again
    req(1'b1, 31, 16'hFFFF, ""); req(1'b0, 31, 0, "R3 relock FFFF");
    for (int a = 32; a <= 47; a++) req(1'b1, a, 16'h5555, "");
    sweep("R4 relocked write");

    // R9: open, then out-of-range writes change nothing
    req(1'b1, 31, 16'h1235, "");
    for (int a = 64; a < 128; a++) req(1'b1, a, 16'hDEAD, "");
    sweep("R9 no effect");
    req(1'b1, 31, 16'h0000, ""); req(1'b0, 31, 0, "R3 relock 0000");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule